// File: doc/BRIEF.md
# Single-Channel DMA Transfer Sequencer

The block is one DMA channel. Software loads a source address, a destination address, an 8-bit transfer count and a control word through a small register port. Each transfer request that arrives while the channel is enabled and idle turns into one read from the source address. The data from that read is then written to the destination address. Both accesses run on a simple memory bus with a request/ready handshake. After every completed write, the channel steps each address that is set to increment and decrements the count.

The count is a down-counter that ends a normal run when it steps from 0x00 to 0xFF. Loading N therefore gives N+1 transfers, and loading 0xFF gives 256. At the end of a normal run the channel clears its own enable and sets a sticky completion flag. This flag drives a maskable interrupt. In ring mode the count wraps freely, and the run lasts until software clears the enable. A ring run never sets the completion flag.

Top module: `dma_chan_seq`

## Requirements
- R1: Register map on `reg_addr`: 0 = source address, 1 = destination address, 2 = count (low 8 bits), 3 = control. Control bits: 0 enable, 1 halfword size (0 = byte), 2 source increments, 3 destination increments, 4 ring mode, 5 interrupt mask, 6 completion flag. After reset every register reads 0, `bus_req` is low and `irq` is low.
- R2: A serviced request produces exactly one read at the source address, followed by one write of the read data to the destination address. While `bus_rdy` is low, `bus_addr` and `bus_we` hold their values.
- R3: Each accepted write decrements the count by 1, and a decrement from 0x00 gives 0xFF.
- R4: In normal mode, the write that decrements the count from 0x00 ends the run. The enable bit reads 0 afterwards and the count reads 0xFF. Loading 0xFF gives 256 transfers.
- R5: An address register in fixed mode keeps its programmed value through a run.
- R6: An address register in incrementing mode steps by 1 for byte size and by 2 for halfword size after each write. At completion it holds the last accessed address plus the size.
- R7: Completion sets control bit 6. Only a control write with bit 6 set clears it. `irq` equals bit 6 AND NOT bit 5.
- R8: In ring mode the count wraps through 0xFF and the enable stays 1. The completion flag is never set, including when software clears the enable.
- R9: A control write that clears the enable while a read is pending does not cut the transfer short. The write to the destination still occurs and the count still decrements.
- R10: A request that arrives while the enable is 0, or while a transfer is in progress, is dropped. It is not queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data (combinational) |
| xfer_req | input | 1 | Transfer request |
| bus_req | output | 1 | Bus access valid |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_half | output | 1 | 1 = halfword access |
| bus_addr | output | AW | Access address |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data |
| bus_rdy | input | 1 | Access accepted this cycle |
| irq | output | 1 | Completion interrupt |

## Verification
A wrong address step or a wrong count shows at `bus_addr` on the very next access. It also shows in the register readback as soon as the write that caused it completes. A wrong termination decision appears at the end of the run: the enable bit and `irq` are wrong there, and any later request produces extra or missing bus writes. A corrupted data latch shows in `bus_wdata` one access after the read that fed it.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE} seq_state_t;

  localparam logic [1:0] RA_SRC = 2'd0;
  localparam logic [1:0] RA_DST = 2'd1;
  localparam logic [1:0] RA_CNT = 2'd2;
  localparam logic [1:0] RA_CTL = 2'd3;

  localparam int CB_EN   = 0;
  localparam int CB_HALF = 1;
  localparam int CB_SINC = 2;
  localparam int CB_DINC = 3;
  localparam int CB_RING = 4;
  localparam int CB_MASK = 5;
  localparam int CB_FLAG = 6;
  localparam int CTL_W   = 7;

  // bytes moved by one transfer
  function automatic int unsigned step_bytes(input logic half);
    return half ? 2 : 1;
  endfunction
endpackage

// File: rtl/dma_addr_reg.sv
module dma_addr_reg #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_we,
  input  logic [AW-1:0] sw_data,
  input  logic          adv,
  input  logic          inc,
  input  logic          half,
  output logic [AW-1:0] q
);
  import dma_chan_pkg::*;

  function automatic logic [AW-1:0] next_addr(input logic [AW-1:0] a, input logic h);
    return a + AW'(step_bytes(h));
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          q <= '0;
    else if (adv && inc) q <= next_addr(q, half);
    else if (sw_we)      q <= sw_data;
  end
endmodule

// File: rtl/dma_xfer_cnt.sv
module dma_xfer_cnt #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_we,
  input  logic [CW-1:0] sw_data,
  input  logic          dec,
  output logic [CW-1:0] q,
  output logic          at_zero
);
  assign at_zero = (q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (dec)   q <= q - 1'b1;
    else if (sw_we) q <= sw_data;
  end
endmodule

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm #(
  parameter int DW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              bus_rdy,
  input  logic [DW-1:0]     bus_rdata,
  output dma_chan_pkg::seq_state_t state,
  output logic              rd_acc,
  output logic              wr_acc,
  output logic [DW-1:0]     data_q
);
  import dma_chan_pkg::*;

  seq_state_t nxt;

  assign rd_acc = (state == ST_READ)  && bus_rdy;
  assign wr_acc = (state == ST_WRITE) && bus_rdy;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:  if (start)  nxt = ST_READ;
      ST_READ:  if (rd_acc) nxt = ST_WRITE;
      ST_WRITE: if (wr_acc) nxt = ST_IDLE;
      default:              nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      data_q <= '0;
    end else begin
      state <= nxt;
      if (rd_acc) data_q <= bus_rdata;
    end
  end
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          xfer_req,
  output logic          bus_req,
  output logic          bus_we,
  output logic          bus_half,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_rdy,
  output logic          irq
);
  import dma_chan_pkg::*;

  localparam int CTL_PAD = DW - CTL_W;

  logic          src_we, dst_we, cnt_we, ctl_we;
  logic [AW-1:0] src_q, dst_q, sw_addr;
  logic [CW-1:0] cnt_q;
  logic          cnt_zero;
  logic          en_q, half_q, sinc_q, dinc_q, ring_q, mask_q, flag_q;
  seq_state_t    state;
  logic          rd_acc, wr_acc, start, done_evt;
  logic [DW-1:0] data_q;
  logic [CTL_W-1:0] ctl_view;

  assign src_we  = reg_we && (reg_addr == RA_SRC);
  assign dst_we  = reg_we && (reg_addr == RA_DST);
  assign cnt_we  = reg_we && (reg_addr == RA_CNT);
  assign ctl_we  = reg_we && (reg_addr == RA_CTL);
  assign sw_addr = AW'(reg_wdata);

  // named internal events
  assign start    = xfer_req && en_q && (state == ST_IDLE);
  assign done_evt = wr_acc && cnt_zero && !ring_q;

  dma_addr_reg #(.AW(AW)) u_src (
    .clk(clk), .rst_n(rst_n), .sw_we(src_we), .sw_data(sw_addr),
    .adv(wr_acc), .inc(sinc_q), .half(half_q), .q(src_q)
  );

  dma_addr_reg #(.AW(AW)) u_dst (
    .clk(clk), .rst_n(rst_n), .sw_we(dst_we), .sw_data(sw_addr),
    .adv(wr_acc), .inc(dinc_q), .half(half_q), .q(dst_q)
  );

  dma_xfer_cnt #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .sw_we(cnt_we), .sw_data(CW'(reg_wdata)),
    .dec(wr_acc), .q(cnt_q), .at_zero(cnt_zero)
  );

  dma_seq_fsm #(.DW(DW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .bus_rdy(bus_rdy),
    .bus_rdata(bus_rdata), .state(state), .rd_acc(rd_acc),
    .wr_acc(wr_acc), .data_q(data_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      half_q <= 1'b0;
      sinc_q <= 1'b0;
      dinc_q <= 1'b0;
      ring_q <= 1'b0;
      mask_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      if (ctl_we) begin
        half_q <= reg_wdata[CB_HALF];
        sinc_q <= reg_wdata[CB_SINC];
        dinc_q <= reg_wdata[CB_DINC];
        ring_q <= reg_wdata[CB_RING];
        mask_q <= reg_wdata[CB_MASK];
      end
      if (done_evt)    en_q <= 1'b0;
      else if (ctl_we) en_q <= reg_wdata[CB_EN];
      if (done_evt)                           flag_q <= 1'b1;
      else if (ctl_we && reg_wdata[CB_FLAG])  flag_q <= 1'b0;
    end
  end

  assign ctl_view = {flag_q, mask_q, ring_q, dinc_q, sinc_q, half_q, en_q};

  always_comb begin
    unique case (reg_addr)
      RA_SRC:  reg_rdata = DW'(src_q);
      RA_DST:  reg_rdata = DW'(dst_q);
      RA_CNT:  reg_rdata = DW'(cnt_q);
      default: reg_rdata = {{CTL_PAD{1'b0}}, ctl_view};
    endcase
  end

  assign bus_req   = (state != ST_IDLE);
  assign bus_we    = (state == ST_WRITE);
  assign bus_half  = half_q;
  assign bus_addr  = (state == ST_WRITE) ? dst_q : src_q;
  assign bus_wdata = data_q;
  assign irq       = flag_q && !mask_q;
endmodule

// File: rtl/dma_chan_seq_chk.sv
module dma_chan_seq_chk #(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_req,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic          bus_rdy,
  input logic          irq,
  input logic          mask,
  input logic          ring,
  input logic          en,
  input logic          flag,
  input logic          rd_acc,
  input logic          wr_acc,
  input logic          done_evt,
  input logic [CW-1:0] cnt
);
  // R2
  we_in_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |-> bus_req);

  // R2
  hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_rdy) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));

  // R9
  rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |=> (bus_req && bus_we));

  // R3
  cnt_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc |=> (CW'(cnt + 1'b1) == $past(cnt)));

  // R4
  done_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> (!en && flag));

  // R8
  ring_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ring && !flag) |=> !flag);

  // R7
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(wr_acc) || $fell(mask)));

  // R10
  idle_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !bus_req) |=> !bus_req);
endmodule

bind dma_chan_seq dma_chan_seq_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_rdy(bus_rdy), .irq(irq), .mask(mask_q),
  .ring(ring_q), .en(en_q), .flag(flag_q), .rd_acc(rd_acc),
  .wr_acc(wr_acc), .done_evt(done_evt), .cnt(cnt_q)
);

// File: tb/dma_chan_seq_bench.sv
module dma_chan_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_we = 1'b0;
  logic [1:0]    reg_addr = 2'd0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic          xfer_req = 1'b0;
  logic          bus_req, bus_we, bus_half, bus_rdy, irq;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic          rdy_en = 1'b1;

  int n_chk = 0;
  int n_fail = 0;
  int n_wr = 0;
  logic [AW-1:0] last_wa;
  logic [DW-1:0] last_wd;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chan_seq #(.AW(AW), .DW(DW), .CW(CW)) u_dma_chan_seq (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xfer_req(xfer_req),
    .bus_req(bus_req), .bus_we(bus_we), .bus_half(bus_half),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rdy(bus_rdy), .irq(irq)
  );

  // memory model: data is a fixed pattern of the address
  function automatic logic [DW-1:0] mem_pat(input logic [AW-1:0] a);
    return {a[7:0] ^ 8'h5A, a[7:0]};
  endfunction

  assign bus_rdy   = bus_req & rdy_en;
  assign bus_rdata = mem_pat(bus_addr);

  always @(posedge clk) begin
    if (bus_req && bus_we && bus_rdy) begin
      n_wr    <= n_wr + 1;
      last_wa <= bus_addr;
      last_wd <= bus_wdata;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [DW-1:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [DW-1:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic pulse_req();
    xfer_req = 1'b1;
    @(negedge clk);
    xfer_req = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  typedef struct packed {
    logic        half;
    logic        sinc;
    logic        dinc;
    logic        mask;
    logic [15:0] src;
    logic [15:0] dst;
    logic [7:0]  cnt;
    logic [15:0] esrc;
    logic [15:0] edst;
    logic        eirq;
  } vec_t;

  localparam int NV = 4;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b1, 1'b1, 1'b0, 16'h0100, 16'h0200, 8'd2, 16'h0103, 16'h0203, 1'b1},
    '{1'b1, 1'b1, 1'b0, 1'b0, 16'h1000, 16'h2000, 8'd1, 16'h1004, 16'h2000, 1'b1},
    '{1'b1, 1'b0, 1'b1, 1'b1, 16'h0040, 16'h0800, 8'd3, 16'h0040, 16'h0808, 1'b0},
    '{1'b0, 1'b0, 1'b0, 1'b0, 16'h0011, 16'h0022, 8'd0, 16'h0011, 16'h0022, 1'b1}
  };

  logic done_run = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_run) begin
      n_fail++;
      $display("FAIL R2 watchdog expired actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] rv;
    int w0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd_reg(a[1:0], rv);
      chk("R1 reset register", rv, 0);
    end
    chk("R1 reset bus_req", bus_req, 0);
    chk("R1 reset irq", irq, 0);

    // vector table: normal runs
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      int stp;
      logic [AW-1:0] lsrc, ldst;
      v = VECS[i];
      stp = v.half ? 2 : 1;
      wr_reg(2'd0, v.src);
      wr_reg(2'd1, v.dst);
      wr_reg(2'd2, DW'(v.cnt));
      w0 = n_wr;
      wr_reg(2'd3, DW'({v.mask, 1'b0, v.dinc, v.sinc, v.half, 1'b1}));
      for (int t = 0; t <= int'(v.cnt); t++) pulse_req();
      lsrc = v.sinc ? AW'(v.esrc - stp) : v.src;
      ldst = v.dinc ? AW'(v.edst - stp) : v.dst;
      rd_reg(2'd0, rv); chk("R5/R6 source address", rv, v.esrc);
      rd_reg(2'd1, rv); chk("R5/R6 destination address", rv, v.edst);
      rd_reg(2'd2, rv); chk("R4 count after run", rv, 16'h00FF);
      rd_reg(2'd3, rv); chk("R4 enable cleared", rv[0], 0);
      chk("R7 flag set", rv[6], 1);
      chk("R7 irq vs mask", irq, v.eirq);
      chk("R2 write count", n_wr - w0, int'(v.cnt) + 1);
      chk("R2 last write address", last_wa, ldst);
      chk("R2 last write data", last_wd, mem_pat(lsrc));
      pulse_req();
      chk("R4 stopped after run", n_wr - w0, int'(v.cnt) + 1);
      wr_reg(2'd3, 16'h0040);
      rd_reg(2'd3, rv); chk("R7 flag cleared by write 1", rv[6], 0);
      chk("R7 irq low after clear", irq, 0);
    end

    // R10 request while disabled
    wr_reg(2'd2, 16'd5);
    w0 = n_wr;
    xfer_req = 1'b1;
    @(negedge clk);
    chk("R10 no access while disabled", bus_req, 0);
    xfer_req = 1'b0;
    repeat (3) @(negedge clk);
    wr_reg(2'd3, 16'h0001);
    repeat (3) @(negedge clk);
    chk("R10 disabled request not queued", n_wr - w0, 0);
    rd_reg(2'd2, rv); chk("R10 count untouched", rv, 16'd5);

    // R10 request while busy, and R2 hold during stall
    rdy_en = 1'b0;
    xfer_req = 1'b1; @(negedge clk); xfer_req = 1'b0;
    repeat (2) @(negedge clk);
    xfer_req = 1'b1; @(negedge clk); xfer_req = 1'b0;
    chk("R2 read held during stall", {bus_req, bus_we}, 2'b10);
    rdy_en = 1'b1;
    repeat (6) @(negedge clk);
    chk("R10 busy request dropped", n_wr - w0, 1);
    rd_reg(2'd2, rv); chk("R3 count decrement", rv, 16'd4);

    // R9 disable while a read is pending
    rdy_en = 1'b0;
    xfer_req = 1'b1; @(negedge clk); xfer_req = 1'b0;
    wr_reg(2'd3, 16'h0000);
    chk("R9 access continues after disable", bus_req, 1);
    rdy_en = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 write completed", n_wr - w0, 2);
    rd_reg(2'd2, rv); chk("R9 count decremented", rv, 16'd3);
    rd_reg(2'd3, rv); chk("R9 enable stays 0", rv[0], 0);
    chk("R9 no irq", irq, 0);

    // R8 ring mode wraps, no flag
    wr_reg(2'd0, 16'h0300);
    wr_reg(2'd2, 16'd1);
    wr_reg(2'd3, 16'h0015);
    for (int t = 0; t < 5; t++) pulse_req();
    rd_reg(2'd2, rv); chk("R8 count wraps", rv, 16'h00FC);
    rd_reg(2'd0, rv); chk("R6 ring source step", rv, 16'h0305);
    rd_reg(2'd3, rv); chk("R8 enable kept", rv[0], 1);
    chk("R8 flag not set", rv[6], 0);
    wr_reg(2'd3, 16'h0014);
    rd_reg(2'd3, rv); chk("R8 no flag on disable", rv[6], 0);
    chk("R8 no irq", irq, 0);

    // R4 256 transfers from 0xFF
    wr_reg(2'd1, 16'h4000);
    wr_reg(2'd2, 16'h00FF);
    w0 = n_wr;
    wr_reg(2'd3, 16'h0009);
    for (int t = 0; t < 256; t++) pulse_req();
    chk("R4 256 writes", n_wr - w0, 256);
    rd_reg(2'd1, rv); chk("R6 destination after 256", rv, 16'h4100);
    rd_reg(2'd2, rv); chk("R4 count 0xFF after 256", rv, 16'h00FF);
    chk("R7 irq after 256", irq, 1);

    // R7 sticky: writing 0 to bit 6 does not clear
    wr_reg(2'd3, 16'h0008);
    repeat (5) @(negedge clk);
    chk("R7 flag sticky", irq, 1);
    wr_reg(2'd3, 16'h0028);
    chk("R7 mask hides irq", irq, 0);
    rd_reg(2'd3, rv); chk("R7 flag still set under mask", rv[6], 1);

    done_run = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule